// File: doc/BRIEF.md
# Register-Mapped SPI Master Core

This block is a single-lane SPI master controlled through a simple 32-bit register bus. Software selects a clock mode, a word width of 8 or 16 bits and a bit order for each direction, picks one of eight chip-select lines, and then writes a word to the data-out register. The block shifts that word out on MOSI and, at the same time, gathers a word from MISO. When the last bit has been shifted, it raises a completion flag in the cause register and holds the received word in the data-in register.

The SCLK rate is set outside the block. An external single-cycle enable, `bit_tick`, marks each SCLK edge. Each tick during a transfer moves SCLK by one half period, so one word of N bits takes 2N ticks. A small delay line on MISO lets the sampling point slide back by up to three core-clock cycles. This serves slaves whose data arrives close to the sampling edge.

The bus is write-strobed with a combinational read. The byte offsets are control 0x00, configuration 0x04, data-out 0x08, data-in 0x0C, cause 0x10 and timing 0x18. Any other offset reads zero.

Top module: `spi_regbus_master`

## Requirements
- R1: After reset all `cs_n` lines are high, `sclk` is 0, the configuration and cause registers read 0, data-in reads 0 and the timing register reads 0x40 (sample delay 1).
- R2: Control bits [4:2] hold a chip-select index and control bit 0 is the assert bit. While bit 0 is 1, only `cs_n[index]` is driven low. While bit 0 is 0, all eight lines are high. At most one line is ever low.
- R3: Configuration bit 11 (CPOL) gives the SCLK idle level and bit 12 (CPHA) gives the sampling edge. With CPHA=0, MOSI holds bit k before the leading edge of bit period k and MISO is sampled on that leading edge. With CPHA=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge. All four combinations work.
- R4: Configuration bit 13 set sends the data-out word LSB first; clear sends it MSB first.
- R5: Configuration bit 14 set places the first received bit at bit 0 of data-in; clear places it at the top bit of the word.
- R6: Configuration bit 5 set selects 16-bit words (32 ticks). Clear selects 8-bit words (16 ticks), using data-out bits [7:0].
- R7: A write to data-out while idle starts one word transfer, with cause bit 1 (busy) reading 1 from the next cycle on. A zero word drives MOSI low for every bit.
- R8: Cause bit 0 becomes 1 on the clock edge that takes the last tick, and busy returns to 0 on the same edge. Writing the cause register with data bit 0 equal to 0 clears bit 0.
- R9: At completion, the received word is written to data-in, zero-extended to 32 bits. It holds there through register writes until the next completion.
- R10: A data-out write during a transfer is ignored. The data-out readback keeps the word in flight, and the transfer in progress finishes with its original data and length.
- R11: Timing bits [7:6] hold a sample delay d from 0 to 3. The bit taken at a sampling edge is the MISO value from d core-clock cycles before that edge.
- R12: While no transfer is running, `sclk` equals the CPOL bit. During a transfer, `sclk` toggles on every tick and never changes between ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| bit_tick | input | 1 | One-cycle enable marking each SCLK edge |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | SPI clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 8 | Active-low chip selects |

## Verification
The assertions check the following on every cycle:
- at most one chip select is low;
- SCLK changes exactly at ticks during a transfer;
- a data-out write while busy leaves the data-out word untouched;
- the completion flag is set with busy cleared after the final tick;
- data-in moves only at a completion.

Only the directed scenarios can show the serial content. They check:
- the bit order in each direction for each clock mode and word width;
- the idle SCLK level for each CPOL;
- the chip-select decode;
- which MISO value a given sample delay captures when the slave's data changes one cycle before the edge.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;

  // Register byte offsets
  localparam int OFF_CTRL   = 'h00;
  localparam int OFF_CFG    = 'h04;
  localparam int OFF_DOUT   = 'h08;
  localparam int OFF_DIN    = 'h0C;
  localparam int OFF_CAUSE  = 'h10;
  localparam int OFF_TIMING = 'h18;

  // Field positions
  localparam int CTRL_ASSERT = 0;
  localparam int CTRL_IDX_LO = 2;
  localparam int CFG_WIDE    = 5;
  localparam int CFG_CPOL    = 11;
  localparam int CFG_CPHA    = 12;
  localparam int CFG_TXLSB   = 13;
  localparam int CFG_RXLSB   = 14;
  localparam int TIM_DLY_LO  = 6;
  localparam int CAUSE_DONE  = 0;
  localparam int CAUSE_BUSY  = 1;

  localparam int DLY_W   = 2;
  localparam int MAX_DLY = (1 << DLY_W) - 1;

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic             tx_lsb;
    logic             rx_lsb;
    logic             wide;
    logic [DLY_W-1:0] dly;
  } xfer_cfg_t;

endpackage

// File: rtl/spi_rm_regs.sv
module spi_rm_regs
  import spi_rm_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int WORD_W   = 16,
  parameter int CS_IDX_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic                busy,
  input  logic                done_evt,
  input  logic [WORD_W-1:0]   rx_word,
  output xfer_cfg_t           cfg,
  output logic [CS_IDX_W-1:0] cs_idx,
  output logic                cs_act,
  output logic [WORD_W-1:0]   tx_word,
  output logic [WORD_W-1:0]   din_word,
  output logic                done_flag,
  output logic                start,
  output logic                dout_wr
);

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_DOUT   = ADDR_W'(OFF_DOUT);
  localparam logic [ADDR_W-1:0] A_DIN    = ADDR_W'(OFF_DIN);
  localparam logic [ADDR_W-1:0] A_CAUSE  = ADDR_W'(OFF_CAUSE);
  localparam logic [ADDR_W-1:0] A_TIMING = ADDR_W'(OFF_TIMING);

  xfer_cfg_t           cfg_q;
  logic [CS_IDX_W-1:0] idx_q;
  logic                act_q;
  logic [WORD_W-1:0]   tx_q;
  logic [WORD_W-1:0]   din_q;
  logic                done_q;

  wire ctrl_wr   = wr_en && (addr == A_CTRL);
  wire cfg_wr    = wr_en && (addr == A_CFG);
  wire tim_wr    = wr_en && (addr == A_TIMING);
  wire cause_wr  = wr_en && (addr == A_CAUSE);
  wire cause_clr = cause_wr && !wdata[CAUSE_DONE];

  assign dout_wr = wr_en && (addr == A_DOUT);
  assign start   = dout_wr && !busy;

  logic unused_wdata_hi;
  assign unused_wdata_hi = ^wdata[DATA_W-1:WORD_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '{cpol: 1'b0, cpha: 1'b0, tx_lsb: 1'b0, rx_lsb: 1'b0,
                  wide: 1'b0, dly: DLY_W'(1)};
      idx_q  <= '0;
      act_q  <= 1'b0;
      tx_q   <= '0;
      din_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        act_q <= wdata[CTRL_ASSERT];
        idx_q <= wdata[CTRL_IDX_LO +: CS_IDX_W];
      end
      if (cfg_wr) begin
        cfg_q.cpol   <= wdata[CFG_CPOL];
        cfg_q.cpha   <= wdata[CFG_CPHA];
        cfg_q.tx_lsb <= wdata[CFG_TXLSB];
        cfg_q.rx_lsb <= wdata[CFG_RXLSB];
        cfg_q.wide   <= wdata[CFG_WIDE];
      end
      if (tim_wr) cfg_q.dly <= wdata[TIM_DLY_LO +: DLY_W];
      if (start)  tx_q <= wdata[WORD_W-1:0];
      if (done_evt) begin
        din_q  <= rx_word;
        done_q <= 1'b1;
      end else if (cause_clr) begin
        done_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: begin
        rdata[CTRL_ASSERT]              = act_q;
        rdata[CTRL_IDX_LO +: CS_IDX_W]  = idx_q;
      end
      A_CFG: begin
        rdata[CFG_CPOL]  = cfg_q.cpol;
        rdata[CFG_CPHA]  = cfg_q.cpha;
        rdata[CFG_TXLSB] = cfg_q.tx_lsb;
        rdata[CFG_RXLSB] = cfg_q.rx_lsb;
        rdata[CFG_WIDE]  = cfg_q.wide;
      end
      A_DOUT:   rdata = DATA_W'(tx_q);
      A_DIN:    rdata = DATA_W'(din_q);
      A_CAUSE: begin
        rdata[CAUSE_DONE] = done_q;
        rdata[CAUSE_BUSY] = busy;
      end
      A_TIMING: rdata[TIM_DLY_LO +: DLY_W] = cfg_q.dly;
      default:  rdata = '0;
    endcase
  end

  assign cfg       = cfg_q;
  assign cs_idx    = idx_q;
  assign cs_act    = act_q;
  assign tx_word   = tx_q;
  assign din_word  = din_q;
  assign done_flag = done_q;

endmodule

// File: rtl/spi_rm_shift.sv
module spi_rm_shift
  import spi_rm_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  xfer_cfg_t         cfg_in,
  input  logic [WORD_W-1:0] tx_in,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              sclk_run,
  output logic              mosi,
  output logic              done_evt,
  output logic [WORD_W-1:0] rx_word
);

  localparam int IDX_W = $clog2(WORD_W);
  localparam int HC_W  = IDX_W + 1;

  // Number of bits in the current word
  function automatic logic [IDX_W:0] word_len(input logic wide);
    return wide ? (IDX_W+1)'(WORD_W) : (IDX_W+1)'(WORD_W / 2);
  endfunction

  // Position in the word of serial bit number idx
  function automatic logic [IDX_W-1:0] bit_pos(input logic [IDX_W-1:0] idx,
                                               input logic lsb,
                                               input logic [IDX_W:0] len);
    logic [IDX_W:0] t;
    t = len - 1'b1 - {1'b0, idx};
    return lsb ? idx : t[IDX_W-1:0];
  endfunction

  // MISO value from d cycles before now
  function automatic logic pick_delayed(input logic now_v,
                                        input logic [MAX_DLY-1:0] hist,
                                        input logic [DLY_W-1:0] d);
    logic [DLY_W-1:0] k;
    k = d - 1'b1;
    return (d == '0) ? now_v : hist[k];
  endfunction

  xfer_cfg_t          cfg_q;
  logic               busy_q;
  logic               sclk_q;
  logic [HC_W-1:0]    half_q;
  logic [IDX_W-1:0]   obit_q;
  logic [WORD_W-1:0]  tx_q;
  logic [WORD_W-1:0]  rx_q;
  logic [WORD_W-1:0]  rx_next;
  logic [MAX_DLY-1:0] hist_q;
  logic [HC_W:0]      last_half;
  logic [IDX_W:0]     len;

  assign len       = word_len(cfg_q.wide);
  assign last_half = {len, 1'b0} - 1'b1;

  wire              step      = busy_q && tick;
  wire              leading   = !half_q[0];
  wire              samp_evt  = step && (half_q[0] == cfg_q.cpha);
  wire              last_step = step && (half_q == last_half[HC_W-1:0]);
  wire [IDX_W-1:0]  samp_k    = half_q[HC_W-1:1];
  wire              miso_s    = pick_delayed(miso, hist_q, cfg_q.dly);
  wire              adv_out   = cfg_q.cpha ? (leading && (half_q != '0)) : !leading;

  always_comb begin
    rx_next = rx_q;
    if (samp_evt) rx_next[bit_pos(samp_k, cfg_q.rx_lsb, len)] = miso_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      half_q <= '0;
      obit_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
      hist_q <= '0;
    end else begin
      hist_q <= {hist_q[MAX_DLY-2:0], miso};
      if (start) begin
        cfg_q  <= cfg_in;
        busy_q <= 1'b1;
        sclk_q <= cfg_in.cpol;
        half_q <= '0;
        obit_q <= '0;
        tx_q   <= tx_in;
        rx_q   <= '0;
      end else if (step) begin
        half_q <= half_q + 1'b1;
        rx_q   <= rx_next;
        if (last_step) begin
          busy_q <= 1'b0;
          sclk_q <= cfg_q.cpol;
        end else begin
          sclk_q <= !sclk_q;
          if (adv_out) obit_q <= obit_q + 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign sclk_run = sclk_q;
  assign mosi     = busy_q && tx_q[bit_pos(obit_q, cfg_q.tx_lsb, len)];
  assign done_evt = last_step;
  assign rx_word  = rx_next;

endmodule

// File: rtl/spi_rm_csdec.sv
module spi_rm_csdec #(
  parameter int NUM_CS   = 8,
  parameter int CS_IDX_W = 3
) (
  input  logic [CS_IDX_W-1:0] idx,
  input  logic                act,
  output logic [NUM_CS-1:0]   cs_n
);

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_n[i] = !(act && (idx == CS_IDX_W'(i)));
  end

endmodule

// File: rtl/spi_regbus_master.sv
module spi_regbus_master
  import spi_rm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int WORD_W = 16,
  parameter int NUM_CS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              bit_tick,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic [NUM_CS-1:0] cs_n
);

  localparam int CS_IDX_W = $clog2(NUM_CS);

  xfer_cfg_t           cfg_live;
  logic [CS_IDX_W-1:0] cs_idx;
  logic                cs_act;
  logic [WORD_W-1:0]   tx_word;
  logic [WORD_W-1:0]   din_word;
  logic [WORD_W-1:0]   rx_word;
  logic                done_flag;
  logic                start;
  logic                dout_wr;
  logic                xfer_busy;
  logic                done_evt;
  logic                sclk_run;

  spi_rm_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W), .CS_IDX_W(CS_IDX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(bus_rdata), .busy(xfer_busy),
    .done_evt(done_evt), .rx_word(rx_word), .cfg(cfg_live),
    .cs_idx(cs_idx), .cs_act(cs_act), .tx_word(tx_word),
    .din_word(din_word), .done_flag(done_flag), .start(start),
    .dout_wr(dout_wr)
  );

  spi_rm_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_live),
    .tx_in(bus_wdata[WORD_W-1:0]), .tick(bit_tick), .miso(miso),
    .busy(xfer_busy), .sclk_run(sclk_run), .mosi(mosi),
    .done_evt(done_evt), .rx_word(rx_word)
  );

  spi_rm_csdec #(.NUM_CS(NUM_CS), .CS_IDX_W(CS_IDX_W)) u_csdec (
    .idx(cs_idx), .act(cs_act), .cs_n(cs_n)
  );

  assign sclk = xfer_busy ? sclk_run : cfg_live.cpol;

endmodule

// File: rtl/spi_rm_chk.sv
module spi_rm_chk #(
  parameter int WORD_W = 16,
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CS-1:0] cs_n,
  input logic              sclk,
  input logic              busy,
  input logic              tick,
  input logic              dout_wr,
  input logic [WORD_W-1:0] tx_word,
  input logic              done_evt,
  input logic              done_flag,
  input logic [WORD_W-1:0] din
);

  // R2: never more than one select low
  a_r2_cs_onehot0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R10: write during transfer leaves the word in flight alone
  a_r10_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_wr && busy) |=> $stable(tx_word));

  // R8: final tick sets completion and ends busy
  a_r8_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (done_flag && !busy));

  // R9: data-in changes only at completion
  a_r9_din_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable(din));

  // R12: no SCLK movement between ticks
  a_r12_sclk_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(sclk));

  // R12: every non-final tick moves SCLK
  a_r12_sclk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tick && !done_evt) |=> (sclk != $past(sclk)));

endmodule

bind spi_regbus_master spi_rm_chk #(.WORD_W(WORD_W), .NUM_CS(NUM_CS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .busy(xfer_busy),
  .tick(bit_tick), .dout_wr(dout_wr), .tx_word(tx_word),
  .done_evt(done_evt), .done_flag(done_flag), .din(din_word)
);

// File: tb/spi_regbus_master_tb.sv
`timescale 1ns/1ps
module spi_regbus_master_tb_top;

  localparam int G = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bit_tick = 1'b0;
  logic        miso = 1'b0;
  logic        sclk, mosi;
  logic [7:0]  cs_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  spi_regbus_master dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bit_tick(bit_tick),
    .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check(cs_n == 8'hFF, "R1 cs_n", 32'(cs_n), 32'hFF);
    check(sclk == 1'b0, "R1 sclk", 32'(sclk), 0);
    bus_read(5'h04, v); check(v == 0, "R1 cfg", v, 0);
    bus_read(5'h10, v); check(v == 0, "R1 cause", v, 0);
    bus_read(5'h0C, v); check(v == 0, "R1 din", v, 0);
    bus_read(5'h18, v); check(v == 32'h40, "R1 timing", v, 32'h40);
  endtask

  task automatic t_chip_select();
    bit ok = 1'b1;
    for (int i = 0; i < 8; i++) begin
      bus_write(5'h00, 32'((i << 2) | 1));
      #1;
      if (cs_n != ~(8'(1) << i)) ok = 1'b0;
    end
    check(ok, "R2 one line low per index", 32'(cs_n), 32'h7F);
    bus_write(5'h00, 32'(5 << 2));
    #1;
    check(cs_n == 8'hFF, "R2 assert clear", 32'(cs_n), 32'hFF);
  endtask

  // One word transfer with a bench-side slave
  task automatic t_xfer(input string tag, input bit cpol, input bit cpha,
                        input bit txl, input bit rxl, input bit wide,
                        input logic [1:0] dly, input bit late,
                        input logic [15:0] tx, input logic [15:0] slv,
                        input bit midwr);
    logic [31:0] v;
    logic [15:0] got_tx, exp_rx, mask;
    bit sclk_ok = 1'b1;
    int n = wide ? 16 : 8;
    mask = wide ? 16'hFFFF : 16'h00FF;
    got_tx = '0;
    bus_write(5'h04, 32'((cpol << 11) | (cpha << 12) | (txl << 13) |
                         (rxl << 14) | (wide << 5)));
    bus_write(5'h18, 32'(dly) << 6);
    bus_write(5'h00, 32'((2 << 2) | 1));
    bus_write(5'h10, 32'h0);
    bus_write(5'h08, 32'(tx));
    bus_read(5'h10, v);
    check(v == 32'h2, {tag, " R7 busy after start"}, v, 32'h2);
    for (int h = 0; h < 2 * n; h++) begin
      bit samp = ((h % 2) == cpha);
      int k = h / 2;
      logic b = rxl ? slv[k] : slv[n-1-k];
      int waits = G - 1;
      @(negedge clk);
      if (samp) miso = late ? ~b : b;
      if (midwr && h == 3) begin
        bus_write(5'h08, 32'hA5A5);
        waits = waits - 2;
      end
      repeat (waits - 1) @(negedge clk);
      if (waits > 0) @(negedge clk);
      if (samp) begin
        miso = b;
        got_tx[txl ? k : n-1-k] = mosi;
      end
      if (sclk != (cpol ^ h[0])) sclk_ok = 1'b0;
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
    exp_rx = (late && dly != 0) ? (~slv & mask) : (slv & mask);
    check(sclk_ok, {tag, " R3 sclk level before each edge"}, 32'(sclk), 32'(cpol));
    check(got_tx == (tx & mask), {tag, " R4 R6 mosi word"}, 32'(got_tx), 32'(tx & mask));
    bus_read(5'h10, v);
    check(v == 32'h1, {tag, " R8 done and not busy"}, v, 32'h1);
    bus_read(5'h0C, v);
    check(v == 32'(exp_rx), {tag, " R5 R9 R11 data-in"}, v, 32'(exp_rx));
    check(sclk == cpol, {tag, " R12 idle sclk"}, 32'(sclk), 32'(cpol));
    if (midwr) begin
      bus_read(5'h08, v);
      check(v == 32'(tx), {tag, " R10 data-out kept"}, v, 32'(tx));
    end
  endtask

  task automatic t_hold_and_clear();
    logic [31:0] v;
    bus_write(5'h04, 32'h0000_6820);
    bus_write(5'h00, 32'h1);
    bus_write(5'h18, 32'h0);
    bus_read(5'h0C, v);
    check(v == 32'h0000_00C4, "R9 data-in holds", v, 32'hC4);
    bus_write(5'h10, 32'h1);
    bus_read(5'h10, v);
    check(v == 32'h1, "R8 write with bit0 set keeps done", v, 32'h1);
    bus_write(5'h10, 32'h0);
    bus_read(5'h10, v);
    check(v == 32'h0, "R8 clear by zero write", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_chip_select();
    t_xfer("mode0", 0, 0, 0, 0, 0, 2'd1, 0, 16'h00A5, 16'h003C, 0);
    t_xfer("mode1", 0, 1, 1, 0, 0, 2'd1, 0, 16'h0096, 16'h005A, 0);
    t_xfer("mode2", 1, 0, 0, 1, 1, 2'd1, 0, 16'h1234, 16'hBEEF, 0);
    t_xfer("mode3", 1, 1, 1, 1, 1, 2'd1, 0, 16'h8001, 16'h7E01, 1);
    t_xfer("zero R7", 0, 0, 0, 0, 0, 2'd1, 0, 16'h0000, 16'h00FF, 0);
    t_xfer("late d0", 0, 0, 0, 0, 0, 2'd0, 1, 16'h0011, 16'h006B, 0);
    t_xfer("late d2", 0, 1, 0, 0, 0, 2'd2, 1, 16'h0022, 16'h006B, 0);
    t_xfer("d1", 1, 0, 0, 0, 0, 2'd1, 0, 16'h0033, 16'h00C4, 0);
    t_hold_and_clear();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected 0", 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule